// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a register-programmed tick source. A down-counter, 24 bits wide by default, runs from a programmable reload value to zero. On the count after zero it reloads. Each time it steps from one to zero, it sets a sticky wrap flag and can raise a one-cycle interrupt pulse. The counter advances on "count cycles". A count cycle is either every core clock or only the clocks on which an external reference strobe is high. A control bit selects which.

Software uses three word registers on a simple bus with write-enable, read-enable, address and data. The current-value register at offset 0x8 shows the running count. Any write to it zeroes the count and clears the flag, so the counter restarts from the reload value on the next count cycle. The reload register at offset 0x4 holds the period. A reload of N gives a period of N+1 count cycles. The control/status register at offset 0x0 holds the enable, interrupt-enable and source-select bits, and shows the wrap flag. A read of the control register clears the flag, unless a new wrap lands in that same cycle.

The counter core is a two-state machine. EMPTY means the count is zero. RUN means the count is non-zero. The transitions are:
- load: EMPTY to RUN, on a count cycle with a non-zero reload.
- wrap: RUN to EMPTY, on a count cycle taken at a count of one.
- clear: RUN to EMPTY, on a write to the current-value register.

The wrap flag is a second two-state machine, with states CLEAR and SET. The transitions are:
- set: CLEAR to SET, on a wrap.
- read-clear: SET to CLEAR, on a control read with no wrap in the same cycle.
- write-clear: SET to CLEAR, on a write to the current-value register.

Top module: `tick_timer`

## Requirements
- R1: After reset, all registers read zero and the interrupt is low. The control register is at offset 0x0, the reload register at 0x4 and the current value at 0x8. Read data appears on `bus_rdata` in the cycle after `bus_rd_en`. In every other cycle, and for any other offset, `bus_rdata` is zero.
- R2: On each count cycle the count drops by one. A count cycle taken at zero loads the reload value. A reload of N therefore repeats every N+1 count cycles.
- R3: The source-select bit is control bit 2. When it is 1, every clock with enable set is a count cycle. When it is 0, only clocks with `ref_tick` high are count cycles.
- R4: A write of any data to offset 0x8 makes the count zero and clears the flag. This write wins over a count cycle in the same clock.
- R5: A step of the count from one to zero sets the wrap flag (control bit 16). This happens whatever the interrupt-enable bit holds.
- R6: A control read returns the flag and then clears it. When a wrap falls in the same cycle as the read, the read returns 1 and the flag stays set.
- R7: `tick_irq` is high for exactly one cycle. That cycle follows the clock edge at which the count stepped from one to zero, and the pulse occurs only if interrupt-enable (control bit 1) was set.
- R8: A control write changes only bit 0 (enable), bit 1 and bit 2. The flag bit and every other control bit ignore written data, and those other bits read zero.
- R9: Reload writes keep the low 24 data bits. The upper 8 bits of the reload and current-value reads are zero.
- R10: With a reload of zero, the count stays zero, the flag is never set and no interrupt is raised.
- R11: While enable is 0, the count holds its value and no wrap occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | External reference strobe used when source-select is 0 |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (4) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, one cycle after the read strobe |
| tick_irq | output | 1 | One-cycle interrupt pulse on wrap |

## Verification
The bench builds the block with its default parameters: a 24-bit counter, 32-bit data and a 4-bit address. One reload write of all ones exercises truncation to 24 bits and the zero upper byte.

Most phases use reload values below eight, so a wrap occurs every few cycles. This brings the collisions between a wrap and a control read, and between a wrap and a current-value write, within reach in a short run. A long random phase mixes strobed and free-running count sources with these collisions.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // Register byte offsets; software depends on these
    localparam int unsigned OFS_CTRL    = 32'h0;
    localparam int unsigned OFS_RELOAD  = 32'h4;
    localparam int unsigned OFS_CURRENT = 32'h8;

    // Control/status bit positions
    localparam int unsigned CTL_EN_BIT   = 0;
    localparam int unsigned CTL_IE_BIT   = 1;
    localparam int unsigned CTL_SRC_BIT  = 2;
    localparam int unsigned CTL_FLAG_BIT = 16;

    typedef enum logic {
        CNT_EMPTY = 1'b0,
        CNT_RUN   = 1'b1
    } cnt_state_e;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic src;
        logic ie;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tick_down_counter.sv
module tick_down_counter
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wrap_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: load, wrap and clear transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wrap_d  = 1'b0;
        unique case (state_q)
            CNT_EMPTY: begin
                if (clr) begin
                    cnt_d = '0;
                end else if (tick) begin
                    cnt_d   = reload;
                    state_d = (reload != '0) ? CNT_RUN : CNT_EMPTY;
                end
            end
            CNT_RUN: begin
                if (clr) begin
                    cnt_d   = '0;
                    state_d = CNT_EMPTY;
                end else if (tick) begin
                    cnt_d = cnt_q - ONE;
                    if (cnt_q == ONE) begin
                        wrap_d  = 1'b1;
                        state_d = CNT_EMPTY;
                    end
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = CNT_EMPTY;
            end
        endcase
    end

    // outputs
    always_comb begin
        count_o = cnt_q;
        wrap_o  = wrap_d;
    end

endmodule

// File: rtl/tick_wrap_flag.sv
module tick_wrap_flag
    import tick_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic wr_clr,
    input  logic rd_clr,
    input  logic irq_en,
    output logic flag_o,
    output logic irq_o
);

    flag_state_e flag_q, flag_d;
    logic        irq_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= FLG_CLEAR;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            irq_q  <= wrap & irq_en;
        end
    end

    // next state: set, read-clear and write-clear transitions
    always_comb begin
        flag_d = flag_q;
        unique case (flag_q)
            FLG_CLEAR: begin
                if (!wr_clr && wrap) flag_d = FLG_SET;
            end
            FLG_SET: begin
                if (wr_clr)               flag_d = FLG_CLEAR;
                else if (rd_clr && !wrap) flag_d = FLG_CLEAR;
            end
            default: flag_d = FLG_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag_o = (flag_q == FLG_SET);
        irq_o  = irq_q;
    end

endmodule

// File: rtl/tick_regfile.sv
module tick_regfile
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              flag,
    input  logic              wrap,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              cur_clr_o,
    output logic              ctrl_rd_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_CURRENT = ADDR_W'(OFS_CURRENT);

    logic              hit_ctrl, hit_reload, hit_current;
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [DATA_W-1:0] rdata_q, rd_mux;
    logic              wdata_unused;

    assign hit_ctrl     = (addr == A_CTRL);
    assign hit_reload   = (addr == A_RELOAD);
    assign hit_current  = (addr == A_CURRENT);
    assign wdata_unused = ^wdata[DATA_W-1:CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            rdata_q  <= '0;
        end else begin
            if (wr_en && hit_ctrl) begin
                ctrl_q.en  <= wdata[CTL_EN_BIT];
                ctrl_q.ie  <= wdata[CTL_IE_BIT];
                ctrl_q.src <= wdata[CTL_SRC_BIT];
            end
            if (wr_en && hit_reload) reload_q <= wdata[CNT_W-1:0];
            rdata_q <= rd_en ? rd_mux : '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[CTL_EN_BIT]   = ctrl_q.en;
            rd_mux[CTL_IE_BIT]   = ctrl_q.ie;
            rd_mux[CTL_SRC_BIT]  = ctrl_q.src;
            rd_mux[CTL_FLAG_BIT] = flag | wrap;
        end else if (hit_reload) begin
            rd_mux[CNT_W-1:0] = reload_q;
        end else if (hit_current) begin
            rd_mux[CNT_W-1:0] = count;
        end
    end

    assign ctrl_o    = ctrl_q;
    assign reload_o  = reload_q;
    assign cur_clr_o = wr_en & hit_current;
    assign ctrl_rd_o = rd_en & hit_ctrl;
    assign rdata_o   = rdata_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);

    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cur_count;
    logic             cur_clr, ctrl_rd, wrap_now, wrap_flag;
    logic             cnt_en, irq_en, cnt_tick;

    assign cnt_en   = ctrl_w.en;
    assign irq_en   = ctrl_w.ie;
    assign cnt_tick = cnt_en & (ctrl_w.src | ref_tick);

    tick_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .rd_en     (bus_rd_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .count     (cur_count),
        .flag      (wrap_flag),
        .wrap      (wrap_now),
        .ctrl_o    (ctrl_w),
        .reload_o  (reload_w),
        .cur_clr_o (cur_clr),
        .ctrl_rd_o (ctrl_rd),
        .rdata_o   (bus_rdata)
    );

    tick_down_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .clr     (cur_clr),
        .reload  (reload_w),
        .count_o (cur_count),
        .wrap_o  (wrap_now)
    );

    tick_wrap_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap_now),
        .wr_clr (cur_clr),
        .rd_clr (ctrl_rd),
        .irq_en (irq_en),
        .flag_o (wrap_flag),
        .irq_o  (tick_irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_irq,
    input logic [CNT_W-1:0]  cur_count,
    input logic              wrap_flag,
    input logic              cnt_en,
    input logic              irq_en
);

    logic cur_write;
    assign cur_write = bus_wr_en && (bus_addr == ADDR_W'(OFS_CURRENT));

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq);

    // R7
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> (cur_count == '0 && wrap_flag && $past(irq_en)));

    // R4
    cur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_write |=> (cur_count == '0 && !wrap_flag));

    // R11
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cur_write) |=> $stable(cur_count));

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:CNT_W] == '0);

endmodule

bind tick_timer tick_timer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_tick_timer_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .tick_irq  (tick_irq),
    .cur_count (cur_count),
    .wrap_flag (wrap_flag),
    .cnt_en    (cnt_en),
    .irq_en    (irq_en)
);

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string req = "R1";

    // reference model state
    int unsigned m_cur = 0, m_rel = 0;
    bit m_en = 0, m_ie = 0, m_src = 0, m_flag = 0;
    bit m_tick, m_wcur, m_wrap;
    logic [31:0] exp_rdata = 32'h0;
    logic        exp_irq = 1'b0;

    always #2 clk = ~clk;

    tick_timer u_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .bus_wr_en (wr_en),
        .bus_rd_en (rd_en),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .tick_irq  (irq)
    );

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = 0; m_rel = 0; m_en = 0; m_ie = 0; m_src = 0; m_flag = 0;
            exp_rdata = 32'h0; exp_irq = 1'b0;
        end else begin
            m_tick = m_en && (m_src || ref_tick);
            m_wcur = wr_en && addr == 4'h8;
            m_wrap = m_tick && !m_wcur && m_cur == 1;
            if (rd_en) begin
                case (addr)
                    4'h0:    exp_rdata = {15'b0, (m_flag || m_wrap), 13'b0, m_src, m_ie, m_en};
                    4'h4:    exp_rdata = m_rel;
                    4'h8:    exp_rdata = m_cur;
                    default: exp_rdata = 32'h0;
                endcase
            end else begin
                exp_rdata = 32'h0;
            end
            exp_irq = m_wrap && m_ie;
            if (m_wcur)                    m_flag = 0;
            else if (m_wrap)               m_flag = 1;
            else if (rd_en && addr == 4'h0) m_flag = 0;
            if (m_wcur)      m_cur = 0;
            else if (m_tick) m_cur = (m_cur == 0) ? m_rel : m_cur - 1;
            if (wr_en && addr == 4'h4) m_rel = wdata & 32'h00FF_FFFF;
            if (wr_en && addr == 4'h0) begin
                m_en = wdata[0]; m_ie = wdata[1]; m_src = wdata[2];
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        cycles++;
        vectors += 2;
        if (irq !== exp_irq) begin
            miscompares++;
            $display("FAIL %s irq actual %0b expected %0b at cycle %0d", req, irq, exp_irq, cycles);
        end
        if (rdata !== exp_rdata) begin
            miscompares++;
            $display("FAIL %s rdata actual %h expected %h at cycle %0d", req, rdata, exp_rdata, cycles);
        end
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_read(4'h0); bus_read(4'h4); bus_read(4'h8); bus_read(4'hC);
        idle(2);

        req = "R9";
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4);
        bus_write(4'h8, 32'hDEAD_BEEF);
        bus_read(4'h8);

        req = "R8";
        bus_write(4'h0, 32'hFFFF_FFF8);
        bus_read(4'h0);

        req = "R2";
        bus_write(4'h4, 32'd5);
        bus_write(4'h8, 32'd0);
        bus_write(4'h0, 32'h7);
        for (int i = 0; i < 30; i++) bus_read(4'h8);

        req = "R6";
        bus_write(4'h4, 32'd3);
        for (int i = 0; i < 24; i++) bus_read(4'h0);
        idle(3);
        bus_read(4'h0);
        bus_read(4'h0);

        req = "R7";
        bus_write(4'h0, 32'h5);
        idle(12);
        bus_read(4'h0);

        req = "R5";
        bus_write(4'h0, 32'h7);
        idle(9);
        bus_read(4'h0);

        req = "R4";
        for (int i = 0; i < 12; i++) begin
            bus_write(4'h8, 32'h1234_5678 + i);
            idle(i % 5);
            bus_read(4'h0);
        end

        req = "R3";
        bus_write(4'h0, 32'h3);
        for (int i = 0; i < 40; i++) begin
            ref_tick = (i % 3 == 0);
            rd_en = (i % 2 == 0); addr = 4'h8;
            @(negedge clk);
        end
        rd_en = 1'b0; ref_tick = 1'b0;

        req = "R10";
        bus_write(4'h0, 32'h7);
        bus_write(4'h4, 32'd0);
        bus_write(4'h8, 32'd0);
        for (int i = 0; i < 10; i++) bus_read(4'h0);

        req = "R11";
        bus_write(4'h4, 32'd6);
        idle(4);
        bus_write(4'h0, 32'h0);
        for (int i = 0; i < 10; i++) bus_read(4'h8);

        req = "R2";
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom % 16;
            ref_tick = $urandom % 2;
            wr_en = 1'b0; rd_en = 1'b0;
            if (op < 2) begin
                wr_en = 1'b1; addr = 4'h0; wdata = $urandom;
            end else if (op < 3) begin
                wr_en = 1'b1; addr = 4'h4;
                wdata = ($urandom % 8 == 0) ? $urandom : ($urandom % 7);
            end else if (op < 4) begin
                wr_en = 1'b1; addr = 4'h8; wdata = $urandom;
            end else if (op < 12) begin
                rd_en = 1'b1; addr = 4'((($urandom % 4)) * 4);
            end
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0; ref_tick = 1'b0;
        idle(2);
        finish_run();
    end

endmodule